// File: doc/BRIEF.md
# Downstream Port State Controller

This block runs one downstream port of a hub. It tracks the port through eight states: unpowered, disconnected, connected, resetting, enabled, disabled, suspended and resuming. Its inputs are the sampled line state, the attach level and hub commands. Its outputs are requests for the transceiver to drive SE0 or K, plus status and change bits for the hub logic.

All timing comes from counters in the block's own clock domain. The default parameters assume a 30 MHz clock. Connect and disconnect detection use consecutive-sample debouncing. Reset signalling and resume signalling each have a fixed length. A K seen on a suspended port is debounced, then reported upstream with a one-cycle pulse. One instance is placed per port.

Top module: `dsport_ctrl`

## Requirements
- R1: While rst_n is low, port_state is 0 and every output is 0. While pwr_en is low, the port goes to 0 (OFF) on the next edge from any state. When pwr_en is high in OFF, the port goes to 1 (DISCONNECTED) on the next edge. State codes: 0 OFF, 1 DISCONNECTED, 2 CONNECTED, 3 RESETTING, 4 ENABLED, 5 DISABLED, 6 SUSPENDED, 7 RESUMING.
- R2: In DISCONNECTED, after ln_attach has been sampled high on CONN_DB_CYC consecutive edges, the next edge moves the port to CONNECTED and sets conn_chg. Any low sample restarts the count. The default of 3000 cycles (100 us) lies between 2.5 us and 2000 us.
- R3: In any state from 2 to 7, after ln_attach has been sampled low on DISC_DB_CYC consecutive edges, the next edge moves the port to DISCONNECTED, clears port_enabled and sets conn_chg. The default of 66 cycles (2.2 us) lies between 2.0 us and 2.5 us.
- R4: cmd_reset in CONNECTED, ENABLED, DISABLED or SUSPENDED moves the port to RESETTING on the next edge. drv_se0 is then high for exactly RST_CYC cycles, after which the port is ENABLED with rst_chg set. The default of 360000 cycles is 12 ms.
- R5: cmd_suspend takes effect only in ENABLED, where it moves the port to SUSPENDED on the next edge. In any other state it has no effect.
- R6: cmd_resume takes effect only in SUSPENDED. The port enters RESUMING, drv_k is high for exactly RSM_CYC cycles, and the port then goes to ENABLED with susp_chg set. The default of 630000 cycles is 21 ms.
- R7: In SUSPENDED, after ln_state has been sampled as K (code 2) on KDET_CYC consecutive edges, the next edge moves the port to RESUMING and pulses up_resume high for one cycle. The default of 75 cycles lies far below 1 ms. A K line state outside SUSPENDED has no effect. Line codes: 0 SE0, 1 J, 2 K, 3 SE1.
- R8: cmd_disable in states 2, 3, 4, 6 or 7 moves the port to DISABLED on the next edge, where drv_se0 and drv_k are both low.
- R9: A pulse on clr_conn_chg, clr_rst_chg or clr_susp_chg clears its own change bit on the next edge. If the bit is set in the same cycle, the set wins.
- R10: drv_se0 and drv_k are never high together. drv_se0 is high only in RESETTING and drv_k only in RESUMING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Port power command (level) |
| ln_state | input | 2 | Sampled line state: 0 SE0, 1 J, 2 K, 3 SE1 |
| ln_attach | input | 1 | Sampled attach level |
| cmd_reset | input | 1 | Start port reset (pulse) |
| cmd_suspend | input | 1 | Suspend port (pulse) |
| cmd_resume | input | 1 | Resume port (pulse) |
| cmd_disable | input | 1 | Disable port (pulse) |
| clr_conn_chg | input | 1 | Clear connect-change bit |
| clr_rst_chg | input | 1 | Clear reset-change bit |
| clr_susp_chg | input | 1 | Clear suspend-change bit |
| port_state | output | 3 | Current state code |
| drv_se0 | output | 1 | Request transceiver to drive SE0 |
| drv_k | output | 1 | Request transceiver to drive K |
| port_enabled | output | 1 | Port enabled (states 4, 6, 7) |
| conn_chg | output | 1 | Connect-change bit |
| rst_chg | output | 1 | Reset-change bit |
| susp_chg | output | 1 | Suspend-change bit |
| up_resume | output | 1 | One-cycle request to rebroadcast resume upstream |

## Verification
port_state is a registered copy of the state, so a wrong transition shows at the ports on the edge after the bad decision. A debounce counter that is off by one moves the CONNECTED or DISCONNECTED entry by one cycle. The bench samples both the cycle just before and the cycle just after the expected entry, so either error is caught. A reset or resume timer with the wrong length keeps drv_se0 or drv_k high too long or too briefly, and the check at the last drive cycle and the first cycle after it reports this. A command accepted in the wrong state changes port_state within one cycle.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_DISC = 3'd1,
    PS_CONN = 3'd2,
    PS_RST  = 3'd3,
    PS_EN   = 3'd4,
    PS_DIS  = 3'd5,
    PS_SUSP = 3'd6,
    PS_RSM  = 3'd7
  } port_st_e;

  localparam logic [1:0] LN_SE0 = 2'd0;
  localparam logic [1:0] LN_J   = 2'd1;
  localparam logic [1:0] LN_K   = 2'd2;
  localparam logic [1:0] LN_SE1 = 2'd3;
endpackage

// File: rtl/dsp_hold_filt.sv
module dsp_hold_filt #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic held
);
  localparam int unsigned W = $clog2(HOLD + 1);
  localparam logic [W-1:0] HOLD_W = W'(HOLD);

  logic [W-1:0] cnt_q, cnt_d;

  assign held = (cnt_q == HOLD_W);

  always_comb begin
    cnt_d = cnt_q;
    if (!cond)      cnt_d = '0;
    else if (!held) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2/R3/R7: the run counter never passes its limit
  a_r2_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= HOLD_W);
  // R2/R3/R7: a false sample restarts the count
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> cnt_q == '0);
endmodule

// File: rtl/dsp_dtimer.sv
module dsp_dtimer #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;

  assign done = run_q && (cnt_q == W'(1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load) begin
      cnt_d = ld_val;
      run_d = 1'b1;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == W'(1)) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R4/R6: a running timer never sits at zero
  a_r4_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q != '0);
  // R4/R6: expiry stops the timer unless it is reloaded
  a_r6_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !run_q);
endmodule

// File: rtl/dsp_port_fsm.sv
module dsp_port_fsm
  import dsp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_en,
  input  logic     conn_held,
  input  logic     disc_held,
  input  logic     k_held,
  input  logic     tmr_done,
  input  logic     cmd_reset,
  input  logic     cmd_suspend,
  input  logic     cmd_resume,
  input  logic     cmd_disable,
  input  logic     clr_conn_chg,
  input  logic     clr_rst_chg,
  input  logic     clr_susp_chg,
  output port_st_e st,
  output logic     tmr_load,
  output logic     tmr_sel_rsm,
  output logic     conn_chg,
  output logic     rst_chg,
  output logic     susp_chg,
  output logic     up_resume
);
  port_st_e st_d;
  logic set_c, set_r, set_s, rsm_up;
  logic cc_d, rc_d, sc_d;
  logic attached;

  assign attached = (st != PS_OFF) && (st != PS_DISC);

  always_comb begin
    st_d        = st;
    tmr_load    = 1'b0;
    tmr_sel_rsm = 1'b0;
    set_c       = 1'b0;
    set_r       = 1'b0;
    set_s       = 1'b0;
    rsm_up      = 1'b0;
    if (!pwr_en) begin
      st_d = PS_OFF;
    end else if (attached && disc_held) begin
      st_d  = PS_DISC;
      set_c = 1'b1;
    end else begin
      unique case (st)
        PS_OFF:  st_d = PS_DISC;
        PS_DISC: if (conn_held) begin
          st_d  = PS_CONN;
          set_c = 1'b1;
        end
        PS_CONN, PS_DIS: if (cmd_reset) begin
          st_d     = PS_RST;
          tmr_load = 1'b1;
        end else if (cmd_disable && st == PS_CONN) begin
          st_d = PS_DIS;
        end
        PS_RST: if (cmd_disable) begin
          st_d = PS_DIS;
        end else if (tmr_done) begin
          st_d  = PS_EN;
          set_r = 1'b1;
        end
        PS_EN: if (cmd_reset) begin
          st_d     = PS_RST;
          tmr_load = 1'b1;
        end else if (cmd_disable) begin
          st_d = PS_DIS;
        end else if (cmd_suspend) begin
          st_d = PS_SUSP;
        end
        PS_SUSP: if (cmd_reset) begin
          st_d     = PS_RST;
          tmr_load = 1'b1;
        end else if (cmd_disable) begin
          st_d = PS_DIS;
        end else if (cmd_resume) begin
          st_d        = PS_RSM;
          tmr_load    = 1'b1;
          tmr_sel_rsm = 1'b1;
        end else if (k_held) begin
          st_d        = PS_RSM;
          tmr_load    = 1'b1;
          tmr_sel_rsm = 1'b1;
          rsm_up      = 1'b1;
        end
        PS_RSM: if (cmd_disable) begin
          st_d = PS_DIS;
        end else if (tmr_done) begin
          st_d  = PS_EN;
          set_s = 1'b1;
        end
        default: st_d = PS_OFF;
      endcase
    end
  end

  always_comb begin
    cc_d = set_c | (conn_chg & ~clr_conn_chg);
    rc_d = set_r | (rst_chg  & ~clr_rst_chg);
    sc_d = set_s | (susp_chg & ~clr_susp_chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PS_OFF;
      conn_chg  <= 1'b0;
      rst_chg   <= 1'b0;
      susp_chg  <= 1'b0;
      up_resume <= 1'b0;
    end else begin
      st        <= st_d;
      conn_chg  <= cc_d;
      rst_chg   <= rc_d;
      susp_chg  <= sc_d;
      up_resume <= rsm_up;
    end
  end

  a_r1_pwr_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> st == PS_OFF);
  a_r2_conn_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_CONN && $past(st) == PS_DISC) |-> ($past(conn_held) && conn_chg));
  a_r3_disc_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_DISC && $past(st) != PS_DISC && $past(st) != PS_OFF) |-> conn_chg);
  a_r4_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == PS_RST && st == PS_EN) |-> ($past(tmr_done) && rst_chg));
  a_r5_susp_source: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_SUSP && $past(st) != PS_SUSP) |-> $past(st) == PS_EN);
  a_r6_rsm_source: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_RSM && $past(st) != PS_RSM) |-> $past(st) == PS_SUSP);
  a_r7_up_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_resume |-> (st == PS_RSM) || (st == PS_DIS) || (st == PS_DISC) || (st == PS_OFF));
  a_r7_up_single: assert property (@(posedge clk) disable iff (!rst_n)
    up_resume |=> !up_resume);
endmodule

// File: rtl/dsport_ctrl.sv
module dsport_ctrl
  import dsp_pkg::*;
#(
  parameter int unsigned CONN_DB_CYC = 3000,
  parameter int unsigned DISC_DB_CYC = 66,
  parameter int unsigned KDET_CYC    = 75,
  parameter int unsigned RST_CYC     = 360000,
  parameter int unsigned RSM_CYC     = 630000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en,
  input  logic [1:0] ln_state,
  input  logic       ln_attach,
  input  logic       cmd_reset,
  input  logic       cmd_suspend,
  input  logic       cmd_resume,
  input  logic       cmd_disable,
  input  logic       clr_conn_chg,
  input  logic       clr_rst_chg,
  input  logic       clr_susp_chg,
  output logic [2:0] port_state,
  output logic       drv_se0,
  output logic       drv_k,
  output logic       port_enabled,
  output logic       conn_chg,
  output logic       rst_chg,
  output logic       susp_chg,
  output logic       up_resume
);
  localparam int unsigned TMAX = (RST_CYC > RSM_CYC) ? RST_CYC : RSM_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  port_st_e st;
  logic conn_held, disc_held, k_held;
  logic tmr_load, tmr_sel_rsm, tmr_done;
  logic [TW-1:0] tmr_val;
  logic attached;

  assign attached = (st != PS_OFF) && (st != PS_DISC);
  assign tmr_val  = tmr_sel_rsm ? TW'(RSM_CYC) : TW'(RST_CYC);

  dsp_hold_filt #(.HOLD(CONN_DB_CYC)) u_conn_filt (
    .clk(clk), .rst_n(rst_n),
    .cond(ln_attach && st == PS_DISC), .held(conn_held));

  dsp_hold_filt #(.HOLD(DISC_DB_CYC)) u_disc_filt (
    .clk(clk), .rst_n(rst_n),
    .cond(!ln_attach && attached), .held(disc_held));

  dsp_hold_filt #(.HOLD(KDET_CYC)) u_k_filt (
    .clk(clk), .rst_n(rst_n),
    .cond(ln_state == LN_K && st == PS_SUSP), .held(k_held));

  dsp_dtimer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .ld_val(tmr_val), .done(tmr_done));

  dsp_port_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
    .conn_held(conn_held), .disc_held(disc_held), .k_held(k_held),
    .tmr_done(tmr_done),
    .cmd_reset(cmd_reset), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_disable(cmd_disable),
    .clr_conn_chg(clr_conn_chg), .clr_rst_chg(clr_rst_chg), .clr_susp_chg(clr_susp_chg),
    .st(st), .tmr_load(tmr_load), .tmr_sel_rsm(tmr_sel_rsm),
    .conn_chg(conn_chg), .rst_chg(rst_chg), .susp_chg(susp_chg),
    .up_resume(up_resume));

  assign port_state   = st;
  assign drv_se0      = (st == PS_RST);
  assign drv_k        = (st == PS_RSM);
  assign port_enabled = (st == PS_EN) || (st == PS_SUSP) || (st == PS_RSM);

  a_r10_drive_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_se0 && drv_k));
  a_r3_disc_no_en: assert property (@(posedge clk) disable iff (!rst_n)
    (attached && disc_held && pwr_en) |=> !port_enabled);
  a_r8_dis_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && cmd_disable && st == PS_EN && !disc_held) |=> (!drv_se0 && !drv_k));
endmodule

// File: tb/sim_dsport_ctrl.sv
module sim_dsport_ctrl;
  localparam int CDB = 20, DDB = 8, KDB = 6, RSTN = 50, RSMN = 40;
  localparam int F_ST = 0, F_SE0 = 1, F_K = 2, F_EN = 3, F_CC = 4, F_RC = 5, F_SC = 6, F_UR = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_en, ln_attach;
  logic [1:0] ln_state;
  logic cmd_reset, cmd_suspend, cmd_resume, cmd_disable;
  logic clr_conn_chg, clr_rst_chg, clr_susp_chg;
  logic [2:0] port_state;
  logic drv_se0, drv_k, port_enabled, conn_chg, rst_chg, susp_chg, up_resume;

  always #2 clk = ~clk;

  dsport_ctrl #(.CONN_DB_CYC(CDB), .DISC_DB_CYC(DDB), .KDET_CYC(KDB),
                .RST_CYC(RSTN), .RSM_CYC(RSMN)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .ln_state(ln_state), .ln_attach(ln_attach),
    .cmd_reset(cmd_reset), .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
    .cmd_disable(cmd_disable), .clr_conn_chg(clr_conn_chg), .clr_rst_chg(clr_rst_chg),
    .clr_susp_chg(clr_susp_chg), .port_state(port_state), .drv_se0(drv_se0), .drv_k(drv_k),
    .port_enabled(port_enabled), .conn_chg(conn_chg), .rst_chg(rst_chg),
    .susp_chg(susp_chg), .up_resume(up_resume));

  typedef struct {int cyc; int fld; int val; string rq;} item_t;
  item_t sbq[$];
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int obs(int f);
    case (f)
      F_ST:  return int'(port_state);
      F_SE0: return int'(drv_se0);
      F_K:   return int'(drv_k);
      F_EN:  return int'(port_enabled);
      F_CC:  return int'(conn_chg);
      F_RC:  return int'(rst_chg);
      F_SC:  return int'(susp_chg);
      default: return int'(up_resume);
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc == cyc) begin
        n_cmp++;
        if (obs(sbq[i].fld) != sbq[i].val) begin
          n_bad++;
          $display("FAIL %s cycle %0d field %0d: actual %0d expected %0d",
                   sbq[i].rq, cyc, sbq[i].fld, obs(sbq[i].fld), sbq[i].val);
        end
        sbq.delete(i);
      end else if (sbq[i].cyc < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s missed sample field %0d: actual none expected %0d",
                 sbq[i].rq, sbq[i].fld, sbq[i].val);
        sbq.delete(i);
      end
    end
  end

  task automatic expect_at(int dly, int f, int v, string rq);
    item_t it;
    it.cyc = cyc + dly; it.fld = f; it.val = v; it.rq = rq;
    sbq.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle command pulse: 0 reset,1 suspend,2 resume,3 disable,4/5/6 clears
  task automatic pulse(int which);
    case (which)
      0: cmd_reset = 1'b1;
      1: cmd_suspend = 1'b1;
      2: cmd_resume = 1'b1;
      3: cmd_disable = 1'b1;
      4: clr_conn_chg = 1'b1;
      5: clr_rst_chg = 1'b1;
      default: clr_susp_chg = 1'b1;
    endcase
    tick(1);
    cmd_reset = 0; cmd_suspend = 0; cmd_resume = 0; cmd_disable = 0;
    clr_conn_chg = 0; clr_rst_chg = 0; clr_susp_chg = 0;
  endtask

  task automatic do_reset_to_en(string rq);
    expect_at(1, F_ST, 3, rq);
    expect_at(1, F_SE0, 1, rq);
    expect_at(RSTN, F_SE0, 1, rq);
    expect_at(RSTN + 1, F_ST, 4, rq);
    expect_at(RSTN + 1, F_SE0, 0, rq);
    expect_at(RSTN + 1, F_RC, 1, rq);
    pulse(0);
    tick(RSTN + 2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; pwr_en = 0; ln_attach = 0; ln_state = 2'd1;
    cmd_reset = 0; cmd_suspend = 0; cmd_resume = 0; cmd_disable = 0;
    clr_conn_chg = 0; clr_rst_chg = 0; clr_susp_chg = 0;
    tick(4);
    rst_n = 1;
    // R1: reset state
    for (int f = 0; f < 8; f++) expect_at(1, f, 0, "R1");
    tick(3);
    // R1: power on
    pwr_en = 1;
    expect_at(1, F_ST, 1, "R1");
    tick(3);
    // R2: glitch restarts debounce
    ln_attach = 1;
    expect_at(CDB + 1, F_ST, 1, "R2");
    tick(10);
    ln_attach = 0;
    tick(1);
    ln_attach = 1;
    expect_at(CDB, F_ST, 1, "R2");
    expect_at(CDB + 1, F_ST, 2, "R2");
    expect_at(CDB + 1, F_CC, 1, "R2");
    tick(CDB + 3);
    // R9: clear connect change
    expect_at(1, F_CC, 0, "R9");
    pulse(4);
    // R5: suspend ignored when only connected
    expect_at(1, F_ST, 2, "R5");
    expect_at(3, F_ST, 2, "R5");
    pulse(1);
    tick(3);
    // R6: resume ignored when connected
    expect_at(1, F_ST, 2, "R6");
    pulse(2);
    tick(2);
    // R4: port reset
    do_reset_to_en("R4");
    expect_at(1, F_EN, 1, "R4");
    tick(2);
    // R7: K while enabled has no effect
    ln_state = 2'd2;
    expect_at(KDB + 2, F_ST, 4, "R7");
    expect_at(KDB + 2, F_UR, 0, "R7");
    tick(KDB + 4);
    ln_state = 2'd1;
    // R6: resume ignored when enabled
    expect_at(1, F_ST, 4, "R6");
    pulse(2);
    // R9: clear reset change
    expect_at(1, F_RC, 0, "R9");
    pulse(5);
    // R5: suspend from enabled
    expect_at(1, F_ST, 6, "R5");
    pulse(1);
    tick(2);
    // R6: commanded resume
    expect_at(1, F_ST, 7, "R6");
    expect_at(1, F_K, 1, "R6");
    expect_at(1, F_SE0, 0, "R10");
    expect_at(RSMN, F_K, 1, "R6");
    expect_at(RSMN + 1, F_ST, 4, "R6");
    expect_at(RSMN + 1, F_K, 0, "R6");
    expect_at(RSMN + 1, F_SC, 1, "R6");
    expect_at(RSMN + 1, F_UR, 0, "R7");
    pulse(2);
    tick(RSMN + 2);
    expect_at(1, F_SC, 0, "R9");
    pulse(6);
    // R7: detected resume
    expect_at(1, F_ST, 6, "R5");
    pulse(1);
    tick(2);
    ln_state = 2'd2;
    expect_at(KDB, F_ST, 6, "R7");
    expect_at(KDB, F_UR, 0, "R7");
    expect_at(KDB + 1, F_ST, 7, "R7");
    expect_at(KDB + 1, F_UR, 1, "R7");
    expect_at(KDB + 2, F_UR, 0, "R7");
    expect_at(KDB + 1 + RSMN, F_ST, 4, "R7");
    tick(KDB + 3);
    ln_state = 2'd1;
    tick(RSMN + 2);
    // R8: disable from enabled
    expect_at(1, F_ST, 5, "R8");
    expect_at(1, F_EN, 0, "R8");
    pulse(3);
    expect_at(1, F_ST, 5, "R5");
    pulse(1);
    // R8: disable aborts reset drive
    expect_at(1, F_ST, 3, "R4");
    pulse(0);
    tick(5);
    expect_at(1, F_ST, 5, "R8");
    expect_at(1, F_SE0, 0, "R8");
    pulse(3);
    tick(2);
    do_reset_to_en("R4");
    // R3: disconnect from enabled
    ln_attach = 0;
    expect_at(DDB, F_ST, 4, "R3");
    expect_at(DDB + 1, F_ST, 1, "R3");
    expect_at(DDB + 1, F_EN, 0, "R3");
    expect_at(DDB + 1, F_CC, 1, "R3");
    tick(DDB + 3);
    // R1: power off
    pwr_en = 0;
    expect_at(1, F_ST, 0, "R1");
    tick(3);
    while (sbq.size() != 0) tick(1);
    tick(2);
    finish_run();
  end
endmodule